// File: doc/BRIEF.md
# Auto-range gain controller

This block chooses the gain range for a programmable-gain analog front end by watching the ADC samples that come out of it. Each sample arrives with a strobe and a clip flag. The block turns the sample into an absolute magnitude and compares it with a run-time window. When the signal is too large it asks for one step less gain. When it is too small it asks for one step more. Range 0 is the lowest gain and `MAX_RANGE` is the highest.

Every move is guarded. The block must stay in a range for a minimum number of samples before it may move again. After each move it marks a run of samples invalid while the analog path settles. The first valid sample after that must fall inside a narrower confirmation window before the range is declared stable. The confirmation window sits further from the clip threshold than from the low threshold, so the guard on the near-clip side is the wider one. A clip flag always overrides the amplitude checks. A clip that arrives while samples are blanked is held and acted on when blanking ends, unless emergency downshift is enabled.

A downstream consumer uses the per-sample tag to throw away unsettled data. The range output and its change pulse drive the gain network.

Top module: `autorange_ctrl`

## Requirements
- R1: Reset sets the range index to 0 and clears the stable flag and the change pulse. Blanking is active after reset, so the first `cfg_blank` valid samples are tagged invalid.
- R2: Magnitude is the absolute value of the signed sample, and the most negative code counts as its full magnitude. On a sample that is not blanked, magnitude > `cfg_thr_hi` moves the range down by one (index - 1, less gain). On such a sample, magnitude < `cfg_thr_lo` moves the range up by one (index + 1, more gain).
- R3: The range index never changes by more than one per sample. A downward request at index 0 produces no move, and an upward request at `MAX_RANGE` produces no move.
- R4: A clip flag on a sample that is not blanked forces a downward move, whatever the magnitude, and takes priority over an upward request.
- R5: A move caused by amplitude or clip happens only if the number of valid samples seen since the range was entered, not counting the current one, is at least `cfg_dwell`. Blanked samples count toward this number.
- R6: After every move, the next `cfg_blank` valid samples get `tag_ok` = 0. These samples never cause a move or a confirmation, except through R9's emergency path.
- R7: `range_stable` is cleared on every move. It is set by a sample that is not blanked, has no clip, and has `cfg_thr_lo + cfg_band <= magnitude <= cfg_thr_hi - (cfg_band << HI_SHIFT)`. The window ends are inclusive, and `HI_SHIFT` defaults to 1.
- R8: A sample that is not blanked, whose magnitude lies between the two thresholds but outside the R7 window, neither moves the range nor confirms it.
- R9: A clip on a blanked sample is held. When `cfg_emerg_en` = 0, the first sample that is not blanked is then treated as clipped, and the hold is cleared on that sample. When `cfg_emerg_en` = 1 and the index is above 0, a clip on a blanked sample moves the range down at once, ignoring dwell.
- R10: All outputs are registered and respond in the clock cycle after the input sample. `range_chg` is a one-cycle pulse with `range_up` = 1 for a move up. `tag_strobe` pulses once per input sample and stays 0 on idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | SW | Signed ADC sample |
| s_clip | input | 1 | Converter clip indication for this sample |
| cfg_thr_hi | input | SW | Upper magnitude threshold (too large) |
| cfg_thr_lo | input | SW | Lower magnitude threshold (too small) |
| cfg_band | input | SW | Hysteresis guard; the near-clip guard is this value shifted left by HI_SHIFT |
| cfg_dwell | input | CW | Minimum samples in a range before a move |
| cfg_blank | input | CW | Samples tagged invalid after a move |
| cfg_emerg_en | input | 1 | Allow immediate downshift on a clip during blanking |
| range_idx | output | RW | Current gain range, 0 = lowest gain |
| range_chg | output | 1 | One-cycle pulse when the range changes |
| range_up | output | 1 | Direction of the change, 1 = more gain |
| tag_strobe | output | 1 | Per-sample tag strobe |
| tag_ok | output | 1 | Tag value: 1 = sample usable, 0 = blanked |
| range_stable | output | 1 | Current range has been confirmed |

## Verification
Most state errors in this block show up within one sample. A blanking counter that is off by one makes `tag_ok` wrong on the boundary sample in the next cycle. A lost held clip appears as a missing `range_chg` on the first sample after blanking. A wrong dwell count moves the range one sample early or late, and this shows on `range_idx` one cycle after that sample. A wrong hysteresis edge is visible only as `range_stable` set or left clear on an exact window-boundary magnitude, so those values are driven on purpose. Off-by-one errors at the ends of the range index are caught by driving the index to 0 and to `MAX_RANGE`.

// File: rtl/autorange_pkg.sv
package autorange_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_e;
endpackage

// File: rtl/ar_sat_counter.sv
module ar_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != {W{1'b1}}) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ar_mag_cmp.sv
module ar_mag_cmp #(
  parameter int SW       = 16,
  parameter int HI_SHIFT = 1
) (
  input  logic signed [SW-1:0] data,
  input  logic                 clip,
  input  logic                 held_clip,
  input  logic        [SW-1:0] thr_hi,
  input  logic        [SW-1:0] thr_lo,
  input  logic        [SW-1:0] band,
  output logic                 over,
  output logic                 under,
  output logic                 inwin
);
  localparam int WW = SW + HI_SHIFT + 1;

  logic [SW-1:0] mag;
  logic [WW-1:0] mag_w, lo_edge, hi_need;

  always_comb begin
    mag     = data[SW-1] ? SW'(-data) : SW'(data);
    mag_w   = WW'(mag);
    lo_edge = WW'(thr_lo) + WW'(band);
    hi_need = mag_w + (WW'(band) << HI_SHIFT);
    over    = clip | held_clip | (mag > thr_hi);
    under   = mag < thr_lo;
    inwin   = !over && (mag_w >= lo_edge) && (hi_need <= WW'(thr_hi));
  end
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl
  import autorange_pkg::*;
#(
  parameter int SW        = 16,
  parameter int CW        = 8,
  parameter int MAX_RANGE = 7,
  parameter int HI_SHIFT  = 1,
  parameter int RW        = $clog2(MAX_RANGE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic signed [SW-1:0] s_data,
  input  logic                 s_clip,
  input  logic        [SW-1:0] cfg_thr_hi,
  input  logic        [SW-1:0] cfg_thr_lo,
  input  logic        [SW-1:0] cfg_band,
  input  logic        [CW-1:0] cfg_dwell,
  input  logic        [CW-1:0] cfg_blank,
  input  logic                 cfg_emerg_en,
  output logic        [RW-1:0] range_idx,
  output logic                 range_chg,
  output logic                 range_up,
  output logic                 tag_strobe,
  output logic                 tag_ok,
  output logic                 range_stable
);
  localparam logic [RW-1:0] TOP_IDX = RW'(MAX_RANGE);

  logic [CW-1:0] blank_cnt, dwell_cnt;
  logic          held_clip;
  logic          over, under, inwin;
  logic          blanking, dwell_ok, at_bottom, at_top;
  logic          confirm, moved;
  step_e         step;

  ar_mag_cmp #(.SW(SW), .HI_SHIFT(HI_SHIFT)) u_cmp (
    .data      (s_data),
    .clip      (s_clip),
    .held_clip (held_clip),
    .thr_hi    (cfg_thr_hi),
    .thr_lo    (cfg_thr_lo),
    .band      (cfg_band),
    .over      (over),
    .under     (under),
    .inwin     (inwin)
  );

  // decision for the sample on the inputs this cycle
  always_comb begin
    blanking  = blank_cnt < cfg_blank;
    dwell_ok  = dwell_cnt >= cfg_dwell;
    at_bottom = range_idx == '0;
    at_top    = range_idx == TOP_IDX;
    step      = STEP_HOLD;
    confirm   = 1'b0;
    if (s_valid) begin
      if (blanking) begin
        if (s_clip && cfg_emerg_en && !at_bottom) step = STEP_DOWN;
      end else if (over && !at_bottom && dwell_ok) begin
        step = STEP_DOWN;
      end else if (!over && under && !at_top && dwell_ok) begin
        step = STEP_UP;
      end else if (!range_stable && inwin) begin
        confirm = 1'b1;
      end
    end
    moved = step != STEP_HOLD;
  end

  ar_sat_counter #(.W(CW)) u_blank_cnt (
    .clk (clk),
    .rst (rst),
    .clr (moved),
    .inc (s_valid && blanking),
    .cnt (blank_cnt)
  );

  ar_sat_counter #(.W(CW)) u_dwell_cnt (
    .clk (clk),
    .rst (rst),
    .clr (moved),
    .inc (s_valid),
    .cnt (dwell_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      range_idx    <= '0;
      range_chg    <= 1'b0;
      range_up     <= 1'b0;
      tag_strobe   <= 1'b0;
      tag_ok       <= 1'b0;
      range_stable <= 1'b0;
      held_clip    <= 1'b0;
    end else begin
      range_chg  <= moved;
      range_up   <= step == STEP_UP;
      tag_strobe <= s_valid;
      tag_ok     <= s_valid && !blanking;
      case (step)
        STEP_DOWN: range_idx <= range_idx - RW'(1);
        STEP_UP:   range_idx <= range_idx + RW'(1);
        default:   range_idx <= range_idx;
      endcase
      if (moved)        range_stable <= 1'b0;
      else if (confirm) range_stable <= 1'b1;
      if (moved)                              held_clip <= 1'b0;
      else if (s_valid && blanking && s_clip) held_clip <= 1'b1;
      else if (s_valid && !blanking)          held_clip <= 1'b0;
    end
  end
endmodule

// File: rtl/autorange_ctrl_chk.sv
module autorange_ctrl_chk #(
  parameter int RW        = 3,
  parameter int MAX_RANGE = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] range_idx,
  input logic          range_chg,
  input logic          range_up,
  input logic          tag_strobe,
  input logic          tag_ok,
  input logic          range_stable
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (range_idx == '0 && !range_stable && !range_chg));

  a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
    range_idx <= RW'(MAX_RANGE));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    range_chg |-> (range_idx == $past(range_idx) + RW'(1) ||
                   range_idx == $past(range_idx) - RW'(1)));

  a_r10_up_direction: assert property (@(posedge clk) disable iff (rst)
    (range_chg && range_up) |-> range_idx == $past(range_idx) + RW'(1));

  a_r10_no_silent_change: assert property (@(posedge clk) disable iff (rst)
    !range_chg |-> $stable(range_idx));

  a_r7_cleared_on_move: assert property (@(posedge clk) disable iff (rst)
    range_chg |-> !range_stable);

  a_r7_confirm_needs_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(range_stable) |-> (tag_strobe && tag_ok));

  a_r6_tag_with_strobe: assert property (@(posedge clk) disable iff (rst)
    tag_ok |-> tag_strobe);
endmodule

bind autorange_ctrl autorange_ctrl_chk #(.RW(RW), .MAX_RANGE(MAX_RANGE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .range_idx    (range_idx),
  .range_chg    (range_chg),
  .range_up     (range_up),
  .tag_strobe   (tag_strobe),
  .tag_ok       (tag_ok),
  .range_stable (range_stable)
);

// File: tb/tb_autorange_ctrl.sv
`timescale 1ns/1ps
module tb_autorange_ctrl;
  localparam int SW = 16, CW = 8, MAXR = 7, RW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic s_valid = 1'b0, s_clip = 1'b0;
  logic signed [SW-1:0] s_data = '0;
  logic [SW-1:0] cfg_thr_hi = 16'd20000, cfg_thr_lo = 16'd4000, cfg_band = 16'd1000;
  logic [CW-1:0] cfg_dwell = 8'd4, cfg_blank = 8'd3;
  logic cfg_emerg_en = 1'b0;
  logic [RW-1:0] range_idx;
  logic range_chg, range_up, tag_strobe, tag_ok, range_stable;

  always #2.5 clk = ~clk;

  autorange_ctrl #(.SW(SW), .CW(CW), .MAX_RANGE(MAXR)) dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_clip(s_clip),
    .cfg_thr_hi(cfg_thr_hi), .cfg_thr_lo(cfg_thr_lo), .cfg_band(cfg_band),
    .cfg_dwell(cfg_dwell), .cfg_blank(cfg_blank), .cfg_emerg_en(cfg_emerg_en),
    .range_idx(range_idx), .range_chg(range_chg), .range_up(range_up),
    .tag_strobe(tag_strobe), .tag_ok(tag_ok), .range_stable(range_stable)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state, built from the requirements
  int m_range, m_blank, m_dwell;
  bit m_stable, m_held;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_range = 0; m_blank = 0; m_dwell = 0; m_stable = 0; m_held = 0;
  endtask

  function automatic int mag_of(int d);
    return (d < 0) ? -d : d;
  endfunction

  task automatic model_move(int dir, output bit chg, output bit up);
    m_range += dir; m_blank = 0; m_dwell = 0; m_stable = 0; m_held = 0;
    chg = 1; up = (dir > 0);
  endtask

  task automatic model_step(int d, bit c, output bit chg, output bit up, output bit ok);
    int m;
    bit over, under, dok;
    m = mag_of(d);
    chg = 0; up = 0;
    if (m_blank < int'(cfg_blank)) begin
      ok = 0;
      m_blank++;
      if (m_dwell < 255) m_dwell++;
      if (c) begin
        if (cfg_emerg_en && m_range > 0) model_move(-1, chg, up);
        else m_held = 1;
      end
    end else begin
      ok = 1;
      over  = c || m_held || (m > int'(cfg_thr_hi));
      under = m < int'(cfg_thr_lo);
      dok   = m_dwell >= int'(cfg_dwell);
      if (m_dwell < 255) m_dwell++;
      m_held = 0;
      if (over && m_range > 0 && dok) model_move(-1, chg, up);
      else if (!over && under && m_range < MAXR && dok) model_move(1, chg, up);
      else if (!m_stable && !over && m >= int'(cfg_thr_lo) + int'(cfg_band)
               && m + 2 * int'(cfg_band) <= int'(cfg_thr_hi)) m_stable = 1;
    end
  endtask

  task automatic send(int d, bit c, string req);
    bit e_chg, e_up, e_ok;
    @(negedge clk);
    s_valid = 1; s_data = SW'(d); s_clip = c;
    model_step(d, c, e_chg, e_up, e_ok);
    @(negedge clk);
    s_valid = 0; s_clip = 0;
    chk(req, "range_idx", int'(range_idx), m_range);
    chk(req, "range_chg", int'(range_chg), int'(e_chg));
    if (e_chg) chk(req, "range_up", int'(range_up), int'(e_up));
    chk(req, "tag_strobe", int'(tag_strobe), 1);
    chk(req, "tag_ok", int'(tag_ok), int'(e_ok));
    chk(req, "range_stable", int'(range_stable), int'(m_stable));
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int tmp;
    tmp = $urandom(32'h5EED);
    model_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "range_idx", int'(range_idx), 0);
    chk("R1", "range_stable", int'(range_stable), 0);
    chk("R1", "range_chg", int'(range_chg), 0);
    // R1 / R6 blanking after reset, then R7 confirmation
    for (int i = 0; i < 3; i++) send(10000, 0, "R1");
    send(10000, 0, "R7");
    chk("R7", "confirmed", int'(range_stable), 1);
    // R2 upshift on small magnitude once dwell met
    send(100, 0, "R2");
    chk("R2", "up to 1", int'(range_idx), 1);
    for (int i = 0; i < 3; i++) send(100, 0, "R6");
    send(100, 0, "R5");
    chk("R5", "dwell holds", int'(range_idx), 1);
    send(100, 0, "R5");
    chk("R5", "move after dwell", int'(range_idx), 2);
    // R4 clip beats small magnitude
    for (int i = 0; i < 4; i++) send(10000, 0, "R7");
    send(50, 1, "R4");
    chk("R4", "clip downshift", int'(range_idx), 1);
    // R8 hysteresis band, R7 inclusive edges
    for (int i = 0; i < 3; i++) send(10000, 0, "R6");
    send(19000, 0, "R8");
    chk("R8", "no confirm near clip", int'(range_stable), 0);
    send(4500, 0, "R8");
    chk("R8", "no move low band", int'(range_idx), 1);
    send(18000, 0, "R7");
    chk("R7", "upper edge confirms", int'(range_stable), 1);
    // R2 negative magnitudes, R3 bottom saturation
    send(-30000, 0, "R2");
    chk("R2", "negative over", int'(range_idx), 0);
    for (int i = 0; i < 3; i++) send(-32768, 0, "R6");
    send(-32768, 0, "R3");
    chk("R3", "bottom hold", int'(range_idx), 0);
    // R9 held clip, then emergency path
    cfg_dwell = 0;
    send(100, 0, "R2");
    send(10000, 1, "R9");
    send(10000, 0, "R9");
    send(10000, 0, "R9");
    chk("R9", "held, no move yet", int'(range_idx), 1);
    send(10000, 0, "R9");
    chk("R9", "deferred downshift", int'(range_idx), 0);
    cfg_emerg_en = 1;
    for (int i = 0; i < 3; i++) send(100, 0, "R6");
    send(100, 0, "R2");
    send(10000, 1, "R9");
    chk("R9", "emergency downshift", int'(range_idx), 0);
    cfg_emerg_en = 0;
    // R3 top saturation with no blanking
    cfg_blank = 0;
    for (int i = 0; i < 4; i++) send(10000, 0, "R6");
    for (int i = 0; i < 8; i++) send(100, 0, "R3");
    chk("R3", "top hold", int'(range_idx), MAXR);
    // R10 idle cycle
    @(negedge clk);
    chk("R10", "idle tag_strobe", int'(tag_strobe), 0);
    chk("R10", "idle range_chg", int'(range_chg), 0);
    // random mix
    for (int n = 0; n < 2400; n++) begin
      int d, sel;
      bit c;
      if (n % 200 == 0) begin
        @(negedge clk);
        cfg_dwell = CW'($urandom_range(0, 6));
        cfg_blank = CW'($urandom_range(0, 4));
        cfg_emerg_en = $urandom_range(0, 1) == 1;
      end
      sel = $urandom_range(0, 9);
      if (sel < 3) d = $urandom_range(0, 5000);
      else if (sel < 7) d = $urandom_range(3000, 21000);
      else d = $urandom_range(17000, 32767);
      if ($urandom_range(0, 1) == 1) d = -d;
      c = $urandom_range(0, 19) == 0;
      send(d, c, "R2");
      if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule